// File: doc/BRIEF.md
# Serial Port FIFO Error Tracking

This block is a synchronous serial port that acts as the clock master. On the host side it has a transmit queue and a receive queue, each sixteen bytes deep. It also has a status word with two sticky error flags and a write-only clear location. On the line side it drives a serial clock, a transmit data line with a separate output enable, and it takes in a receive data line. While the stream enable is high, the port clocks one byte slot after another with no gap in the serial clock. Each slot takes one byte from the transmit queue and returns one received byte to the receive queue.

The host finds out about lost data through the two flags. The overrun flag records that a received byte found the receive queue full. It does not say which byte was lost, and only a write to the clear location resets it. The underflow flag records that a slot began while the transmit queue had nothing to send. The next byte the host pushes resets it. An interrupt request is raised while the receive queue is at least half full.

Top module: `sspfifo_port`

## Requirements
- R1: After reset both error flags are 0, both fill levels are 0, `sclk`, `txd_oe` and `rx_irq` are low, and the status word reads 0x04 (receive-empty set).
- R2: A write to address 0 pushes `wr_data` into the transmit queue when it holds fewer than 16 bytes, and is dropped otherwise. `tx_level` gives the count, and status bit 3 is set while the count is 16.
- R3: Each byte is shifted out most significant bit first. The byte made from eight receive samples, taken first to last as MSB to LSB, is pushed into the receive queue after the eighth sample.
- R4: `txd` changes only on the system clock edge where `sclk` rises. `rxd` is sampled on the edge where `sclk` falls.
- R5: `txd_oe` is low whenever no slot is running and during a slot that had no data. It is high for the whole of a slot that carries a queued byte.
- R6: While `stream_en` is high, `sclk` toggles every CLK_HALF system clocks, with no pause between slots. After `stream_en` drops, the running slot completes and `sclk` then stays low.
- R7: A slot that starts with the transmit queue empty sets the underflow flag (status bit 1). It still clocks and still receives its eight bits.
- R8: An accepted transmit write clears the underflow flag. If that write falls in the same cycle as a new underflow, the flag stays set.
- R9: A received byte that completes while the receive queue is full, with no pop in that cycle, is dropped. It sets the overrun flag (status bit 0) and leaves the queued bytes unchanged.
- R10: The overrun flag stays set until a write to address 2, whatever data is written. Reads and writes to other addresses do not clear it. A new overrun in the same cycle as the clear write keeps the flag set.
- R11: A host pop from a full receive queue in the same cycle as a received byte completes frees room for that byte. The new byte is stored and no overrun is raised.
- R12: `rx_irq` is high exactly while `rx_level` is 8 or more.
- R13: A read of address 0 pops and returns the oldest received byte. A read of address 0 with the receive queue empty returns 0 and changes nothing. A read of address 1 returns {4'b0, tx_full, rx_empty, underflow, overrun}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stream_en | input | 1 | Keep running byte slots while high |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address (0 data, 2 clear overrun) |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 2 | Host read address (0 data, 1 status) |
| rd_data | output | 8 | Host read data, valid in the cycle of the read |
| sclk | output | 1 | Serial clock |
| txd | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Transmit output enable, low means high impedance |
| rxd | input | 1 | Serial receive data |
| tx_level | output | 5 | Transmit queue fill level |
| rx_level | output | 5 | Receive queue fill level |
| rx_irq | output | 1 | Receive queue at least half full |

## Verification
Two collisions matter. The first is a received byte completing in the same cycle as a host action on a full receive queue, where that action is either a write to the clear location or a pop. The second is the first slot's underflow in the same cycle as a host transmit write. The bench loops the transmit line back to the receive input. It watches for the eighth rising serial edge of a slot and schedules the host strobe so that it lands on the system clock edge of the following fall. For the underflow case it counts cycles from `stream_en`. The result is then read from the flags, from the fill levels, and from the order of the bytes popped afterwards.

// File: rtl/sspfifo_port.sv
module sspfifo_port #(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 16,
  parameter int CLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stream_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sclk,
  output logic              txd,
  output logic              txd_oe,
  input  logic              rxd,
  output logic [$clog2(DEPTH):0] tx_level,
  output logic [$clog2(DEPTH):0] rx_level,
  output logic              rx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam int BW = $clog2(DATA_W);
  localparam int DW = $clog2(CLK_HALF) + 1;
  localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);
  localparam logic [LW-1:0] IRQ_CNT  = LW'(DEPTH / 2);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);
  localparam logic [DW-1:0] LAST_DIV = DW'(CLK_HALF - 1);
  localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_CLR = 2'd2;

  logic [DATA_W-1:0] tx_mem [DEPTH];
  logic [DATA_W-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_cnt, rx_cnt;
  logic          ovr, udr;

  logic              active, sclk_r, oe_r;
  logic [DW-1:0]     div_cnt;
  logic [BW-1:0]     bit_cnt;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-2:0] rx_sh;

  wire tick       = active && (div_cnt == LAST_DIV);
  wire rise       = tick && !sclk_r;
  wire fall       = tick && sclk_r;
  wire slot_start = rise && (bit_cnt == '0) && stream_en;
  wire stop       = rise && (bit_cnt == '0) && !stream_en;
  wire tx_has     = (tx_cnt != '0);
  wire tx_full    = (tx_cnt == FULL_CNT);
  wire rx_empty   = (rx_cnt == '0);

  wire tx_push = wr_en && (wr_addr == A_DATA) && !tx_full;
  wire tx_pop  = slot_start && tx_has;
  wire udr_set = slot_start && !tx_has;
  wire clr_hit = wr_en && (wr_addr == A_CLR);

  wire rx_pop      = rd_en && (rd_addr == A_DATA) && !rx_empty;
  wire rx_push_req = fall && (bit_cnt == LAST_BIT);
  wire rx_room     = (rx_cnt != FULL_CNT) || rx_pop;
  wire rx_push     = rx_push_req && rx_room;
  wire ovr_set     = rx_push_req && !rx_room;
  wire [DATA_W-1:0] rx_byte = {rx_sh, rxd};

  assign sclk     = sclk_r;
  assign txd      = tx_sh[DATA_W-1];
  assign txd_oe   = oe_r;
  assign tx_level = tx_cnt;
  assign rx_level = rx_cnt;
  assign rx_irq   = (rx_cnt >= IRQ_CNT);

  always_comb begin
    case (rd_addr)
      A_DATA:  rd_data = rx_empty ? '0 : rx_mem[rx_rp];
      A_STAT:  rd_data = {{(DATA_W-4){1'b0}}, tx_full, rx_empty, udr, ovr};
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= wr_data;
    if (rx_push) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      ovr <= 1'b0; udr <= 1'b0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      case ({tx_push, tx_pop})
        2'b10:   tx_cnt <= tx_cnt + 1'b1;
        2'b01:   tx_cnt <= tx_cnt - 1'b1;
        default: tx_cnt <= tx_cnt;
      endcase
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      case ({rx_push, rx_pop})
        2'b10:   rx_cnt <= rx_cnt + 1'b1;
        2'b01:   rx_cnt <= rx_cnt - 1'b1;
        default: rx_cnt <= rx_cnt;
      endcase
      if (ovr_set)      ovr <= 1'b1;
      else if (clr_hit) ovr <= 1'b0;
      if (udr_set)      udr <= 1'b1;
      else if (tx_push) udr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; sclk_r <= 1'b0; oe_r <= 1'b0;
      div_cnt <= '0; bit_cnt <= '0; tx_sh <= '0; rx_sh <= '0;
    end else begin
      if (!active) begin
        div_cnt <= '0;
        if (stream_en) active <= 1'b1;
      end else if (tick) begin
        div_cnt <= '0;
        if (stop) begin
          active <= 1'b0;
          oe_r   <= 1'b0;
        end else begin
          sclk_r <= ~sclk_r;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
      if (slot_start) begin
        oe_r  <= tx_has;
        tx_sh <= tx_has ? tx_mem[tx_rp] : '0;
      end else if (rise && bit_cnt != '0) begin
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
      if (fall) begin
        rx_sh   <= rx_byte[DATA_W-2:0];
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
      end
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL_CNT && rx_cnt <= FULL_CNT);                       // R2
  AST_TXD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $rose(sclk));                                  // R4
  AST_OE_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd_oe) |-> ($rose(sclk) || $past(stop)));              // R5
  AST_CLK_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    active && !stop |=> active);                                     // R6
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> (!sclk && bit_cnt == '0));                     // R6
  AST_UDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    udr && tx_push && !udr_set |=> !udr && tx_cnt != '0);            // R8
  AST_OVR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_req && rx_cnt == FULL_CNT && !rx_pop |=> ovr && rx_cnt == FULL_CNT); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !clr_hit |=> ovr);                                        // R10
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_req && rx_pop && rx_cnt == FULL_CNT |=> rx_cnt == FULL_CNT); // R11
endmodule

// File: tb/sspfifo_port_bench.sv
module sspfifo_port_bench;
  localparam int HALF = 2;
  logic clk = 0, rst_n = 0, stream_en = 0, wr_en = 0, rd_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic sclk, txd, txd_oe, rx_irq;
  logic [4:0] tx_level, rx_level;
  wire rxd = txd_oe ? txd : 1'b1;

  sspfifo_port #(.DATA_W(8), .DEPTH(16), .CLK_HALF(HALF)) u_sspfifo_port (
    .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .sclk(sclk), .txd(txd), .txd_oe(txd_oe), .rxd(rxd),
    .tx_level(tx_level), .rx_level(rx_level), .rx_irq(rx_irq));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, rises = 0, first_rise = -1, last_fall = 0, bad_tx = 0, oe_hi = 0;
  int capn = 0, nseen = 0;
  logic [7:0] cap = 0;
  logic [7:0] seen [64];
  logic p_sclk = 0, p_txd = 0;
  event ev8;

  always @(negedge clk) begin
    cyc++;
    if (txd_oe) oe_hi++;
    if (txd !== p_txd && !(sclk && !p_sclk)) bad_tx++;
    if (sclk && !p_sclk) begin
      rises++;
      if (first_rise < 0) first_rise = cyc;
      if (rises % 8 == 0) ->ev8;
    end
    if (!sclk && p_sclk) begin
      last_fall = cyc;
      cap = {cap[6:0], txd};
      capn++;
      if (capn == 8) begin
        if (nseen < 64) seen[nseen] = cap;
        nseen++;
        capn = 0;
      end
    end
    p_sclk = sclk;
    p_txd = txd;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reset_stats();
    rises = 0; first_rise = -1; bad_tx = 0; oe_hi = 0; capn = 0; nseen = 0;
  endtask

  task automatic host_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic host_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic settle();
    repeat (24 * HALF) @(negedge clk);
  endtask

  task automatic start_and_release();
    @(negedge clk); stream_en = 1;
    do @(negedge clk); while (tx_level != 0);
    stream_en = 0;
  endtask

  task automatic drain();
    start_and_release();
    settle();
  endtask

  task automatic hit_push(bit do_pop, output logic [7:0] got);
    got = 0;
    @(ev8);
    @(negedge clk);
    if (do_pop) begin rd_en = 1; rd_addr = 0; #1 got = rd_data; end
    else begin wr_en = 1; wr_addr = 2; wr_data = 8'h00; end
    @(negedge clk); rd_en = 0; wr_en = 0;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 line", {sclk, txd_oe, rx_irq}, 0);
    host_rd(1, s);
    chk("R1 status", s, 8'h04);
  endtask

  task automatic t_loopback();
    logic [7:0] d;
    reset_stats();
    host_wr(0, 8'hA5); host_wr(0, 8'h3C); host_wr(0, 8'h81);
    drain();
    chk("R3 rx_level", rx_level, 3);
    chk("R3 msb first 0", seen[0], 8'hA5);
    chk("R3 msb first 2", seen[2], 8'h81);
    host_rd(0, d); chk("R3 rx byte 0", d, 8'hA5);
    host_rd(0, d); chk("R3 rx byte 1", d, 8'h3C);
    host_rd(0, d); chk("R3 rx byte 2", d, 8'h81);
    chk("R4 txd only on sclk rise", bad_tx, 0);
    chk("R6 rise count", rises, 24);
    chk("R6 no gap", last_fall - first_rise, 47 * HALF);
    chk("R5 oe high span", oe_hi, 48 * HALF);
    chk("R5 R6 idle after stop", {sclk, txd_oe}, 0);
    host_rd(1, d); chk("R7 no underflow", d[1], 0);
  endtask

  task automatic t_underflow();
    logic [7:0] d;
    @(negedge clk); stream_en = 1;
    repeat (HALF) @(negedge clk);
    wr_en = 1; wr_addr = 0; wr_data = 8'h5A;
    @(negedge clk); wr_en = 0;
    host_rd(1, d);
    chk("R8 set wins over write", d[1], 1);
    chk("R2 queued byte", tx_level, 1);
    chk("R5 R7 oe low in empty slot", txd_oe, 0);
    do @(negedge clk); while (tx_level != 0);
    stream_en = 0;
    settle();
    chk("R7 empty slot still receives", rx_level, 2);
    host_rd(0, d); chk("R7 empty slot byte", d, 8'hFF);
    host_rd(0, d); chk("R3 following byte", d, 8'h5A);
    host_rd(1, d); chk("R8 flag held", d[1], 1);
    host_wr(0, 8'h33);
    host_rd(1, d); chk("R8 cleared by write", d[1], 0);
    drain();
    host_rd(0, d); chk("R3 byte after clear", d, 8'h33);
  endtask

  task automatic t_txfull();
    logic [7:0] d;
    for (int i = 0; i < 17; i++) host_wr(0, (i == 16) ? 8'hEE : 8'(8'hC0 + i));
    chk("R2 tx level capped", tx_level, 16);
    host_rd(1, d); chk("R2 tx full bit", d[3], 1);
    drain();
    for (int i = 0; i < 16; i++) begin
      host_rd(0, d); chk("R2 R13 fifo order", d, 8'hC0 + i);
    end
    host_rd(0, d); chk("R13 empty pop value", d, 0);
    chk("R13 empty pop level", rx_level, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    for (int i = 0; i < 16; i++) host_wr(0, 8'(8'h10 + i));
    drain();
    chk("R12 full level", rx_level, 16);
    chk("R12 irq", rx_irq, 1);
    host_rd(1, d); chk("R9 no overrun yet", d[0], 0);
    host_wr(0, 8'h77);
    drain();
    host_rd(1, d); chk("R9 overrun set", d[0], 1);
    chk("R9 level kept", rx_level, 16);
    host_wr(3, 8'hFF);
    host_rd(1, d); chk("R10 sticky", d[0], 1);
    host_wr(0, 8'h78);
    reset_stats();
    start_and_release();
    hit_push(1'b0, d);
    settle();
    host_rd(1, d); chk("R10 set wins over clear", d[0], 1);
    host_wr(2, 8'hA5);
    host_rd(1, d); chk("R10 cleared", d[0], 0);
    host_wr(0, 8'h79);
    reset_stats();
    start_and_release();
    hit_push(1'b1, d);
    chk("R11 popped head", d, 8'h10);
    settle();
    chk("R11 level full", rx_level, 16);
    host_rd(1, d); chk("R11 no overrun", d[0], 0);
    for (int i = 0; i < 16; i++) begin
      host_rd(0, d);
      chk("R9 R11 contents", d, (i == 15) ? 8'h79 : 8'(8'h11 + i));
      if (i == 7) chk("R12 irq at 8", rx_irq, 1);
      if (i == 8) chk("R12 irq at 7", rx_irq, 0);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_loopback();
    t_underflow();
    t_txfull();
    t_overrun();
    finish_run();
  end
endmodule